// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus for a controller whose machine cycle lasts twelve oscillator periods. The first is an active-high address latch strobe, which tells outside logic to capture the low address byte. The second is an active-low code read strobe, which reads external program memory. The block runs a phase counter on the oscillator clock. For each machine cycle it places two address latch pulses and, during external code fetches, two read pulses. Both strobes come from registers, so they carry no decode glitches.

The controller tells the block what each machine cycle is doing. The inputs say whether the cycle fetches code externally, carries a data-memory transfer, or carries a code-table read. Two more inputs say whether execution runs from external memory and whether the address strobe is muted. A data-memory transfer cycle drops the second address pulse and both read pulses. While the mute bit is set, address pulses appear only during data-memory or code-table cycles. In all other cycles the pin is marked for a weak pull-up instead of being driven. External execution overrides the mute bit. A one-period marker at the start of each machine cycle lets the controller align its flags.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `ale_o` is 0, `psen_n_o` is 1, `ale_weak_o` is 0 and `cycle_start_o` is 0. The first rising edge with `rst_n` high begins phase 0 of a machine cycle.
- R2: With the strobe allowed and no data transfer, `ale_o` is 1 in phases 0, 1, 6 and 7 of the 12-phase machine cycle and 0 in the other phases. This gives one pulse per six oscillator periods.
- R3: `cycle_start_o` is 1 in phase 0 only.
- R4: The cycle inputs are sampled on the clock edge that ends phase 11. They govern the whole of the next machine cycle. Input changes at any other time have no effect on that cycle.
- R5: In a cycle flagged as a data transfer (`movx_i`), `ale_o` pulses only in phases 0 and 1, and `psen_n_o` stays 1 for the entire cycle.
- R6: With `ext_fetch_i` set and no data transfer, `psen_n_o` is 0 in phases 2–4 and 8–10 and 1 otherwise. Without `ext_fetch_i` it stays 1.
- R7: When `ale_off_i` is 1 and none of `movx_i`, `movc_i` or `ext_exec_i` is 1, `ale_o` stays 0 for the cycle and `ale_weak_o` is 1 for the entire cycle.
- R8: When `ext_exec_i` is 1, `ale_off_i` has no effect: `ale_o` follows R2/R5 and `ale_weak_o` is 0.
- R9: When `ale_off_i` is 1 with `movc_i` or `movx_i`, `ale_o` pulses as in R2 (or R5 for a data transfer) and `ale_weak_o` is 0.
- R10: `ale_weak_o` is 0 in every cycle in which the address strobe is allowed, and it changes only at the start of a machine cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_fetch_i | input | 1 | Next cycle fetches code from external memory |
| movx_i | input | 1 | Next cycle performs an external data-memory transfer |
| movc_i | input | 1 | Next cycle performs a code-table read |
| ext_exec_i | input | 1 | Execution runs from external program memory |
| ale_off_i | input | 1 | Mute the address latch strobe outside data and table accesses |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Code read strobe, active low |
| ale_weak_o | output | 1 | Address pin left to a weak pull-up instead of driven |
| cycle_start_o | output | 1 | High in phase 0 of each machine cycle |

## Verification
The bench goes after the sampling point of the cycle flags. It drives junk on the inputs in the middle of each cycle, so a design that latched early would show ALE and PSEN pulses that belong to the wrong cycle. It pairs the mute bit with each of the three overriding conditions. A design with a wrong priority would either silence ALE during a table read or external execution, or raise the weak-pullup indication while still pulsing. Data-transfer cycles check that only the second ALE pulse disappears and that no PSEN pulse leaks. An off-by-one in the phase windows would move a pulse edge by one oscillator period, and the per-phase comparisons catch that.

// File: rtl/strobe_pkg.sv
// Shared types for the external bus strobe generator.
package strobe_pkg;
    // Per-machine-cycle request flags, latched once per cycle.
    typedef struct packed {
        logic code_fetch;   // external code fetch in this cycle
        logic data_xfer;    // external data-memory transfer
        logic code_read;    // code-table read
        logic run_external; // execution from external program memory
        logic ale_mute;     // address strobe muted by software bit
    } cyc_flags_t;
endpackage

// File: rtl/mc_phase_ctr.sv
// Machine-cycle phase counter.
// Counts oscillator periods 0..CYC_LEN-1 and reports the next phase so that
// downstream registers can be loaded with values for the coming period.
// Assumes CYC_LEN >= 2. Reset parks the count on the last phase so the first
// clock after reset enters phase 0.
module mc_phase_ctr #(
    parameter int CYC_LEN = 12,
    localparam int PW = $clog2(CYC_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] ph_q,
    output logic [PW-1:0] ph_nxt,
    output logic          wrap
);
    localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);

    // Next-phase decode with wrap at the last phase.
    always_comb begin
        wrap   = (ph_q == LAST);
        ph_nxt = wrap ? '0 : ph_q + 1'b1;
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= LAST;
        else        ph_q <= ph_nxt;
    end
endmodule

// File: rtl/mc_flag_latch.sv
// Holds the request flags for the current machine cycle.
// Loads new flags only when 'load' is high (last phase of a cycle) and
// exposes the value that will be in force during the next period.
module mc_flag_latch
    import strobe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  cyc_flags_t flags_in,
    output cyc_flags_t flags_q,
    output cyc_flags_t flags_nxt
);
    // Select between holding and loading.
    always_comb flags_nxt = load ? flags_in : flags_q;

    // Flag storage register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_nxt;
    end
endmodule

// File: rtl/strobe_window.sv
// Phase window decoder: hit is high when phase lies in [START, START+LEN).
// Purely combinational; assumes START+LEN fits in the phase range.
module strobe_window #(
    parameter int PW    = 4,
    parameter int START = 0,
    parameter int LEN   = 2
) (
    input  logic [PW-1:0] phase,
    output logic          hit
);
    // Range compare against constant bounds.
    always_comb hit = (int'(phase) >= START) && (int'(phase) < START + LEN);
endmodule

// File: rtl/ext_bus_strobe_gen.sv
// External bus strobe generator (top).
// Produces a registered active-high address latch strobe and an active-low
// code read strobe, SLOTS times per machine cycle of CYC_LEN periods.
// The request flags are sampled on the edge that ends each machine cycle.
// A data transfer drops the last address slot and every read slot. The mute
// bit silences the address strobe (pin weakly pulled) unless a data or table
// access is in progress or execution runs externally.
// Assumes ALE_W + PSEN_W <= CYC_LEN / SLOTS.
module ext_bus_strobe_gen
    import strobe_pkg::*;
#(
    parameter int CYC_LEN = 12,
    parameter int SLOTS   = 2,
    parameter int ALE_W   = 2,
    parameter int PSEN_W  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_fetch_i,
    input  logic movx_i,
    input  logic movc_i,
    input  logic ext_exec_i,
    input  logic ale_off_i,
    output logic ale_o,
    output logic psen_n_o,
    output logic ale_weak_o,
    output logic cycle_start_o
);
    localparam int PW       = $clog2(CYC_LEN);
    localparam int SLOT_LEN = CYC_LEN / SLOTS;

    logic [PW-1:0] ph_q;
    logic [PW-1:0] ph_nxt;
    logic          wrap;
    cyc_flags_t    flags_in;
    cyc_flags_t    flags_q;
    cyc_flags_t    flags_nxt;
    logic [SLOTS-1:0] ale_hit;
    logic [SLOTS-1:0] psen_hit;
    logic [SLOTS-1:0] ale_slot_en;
    logic ale_allow;
    logic ale_d;
    logic psen_d;

    // Pack the request inputs.
    always_comb begin
        flags_in.code_fetch   = ext_fetch_i;
        flags_in.data_xfer    = movx_i;
        flags_in.code_read    = movc_i;
        flags_in.run_external = ext_exec_i;
        flags_in.ale_mute     = ale_off_i;
    end

    mc_phase_ctr #(.CYC_LEN(CYC_LEN)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_q   (ph_q),
        .ph_nxt (ph_nxt),
        .wrap   (wrap)
    );

    mc_flag_latch u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wrap),
        .flags_in  (flags_in),
        .flags_q   (flags_q),
        .flags_nxt (flags_nxt)
    );

    // One address window and one read window per slot.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        strobe_window #(.PW(PW), .START(s * SLOT_LEN), .LEN(ALE_W)) u_ale_win (
            .phase (ph_nxt),
            .hit   (ale_hit[s])
        );
        strobe_window #(.PW(PW), .START(s * SLOT_LEN + ALE_W), .LEN(PSEN_W)) u_psen_win (
            .phase (ph_nxt),
            .hit   (psen_hit[s])
        );
        // The last slot of a data-transfer cycle is given to the data access.
        if (s == SLOTS - 1) begin : g_last
            always_comb ale_slot_en[s] = !flags_nxt.data_xfer;
        end else begin : g_early
            always_comb ale_slot_en[s] = 1'b1;
        end
    end

    // Strobe decode for the coming period.
    always_comb begin
        ale_allow = !flags_nxt.ale_mute || flags_nxt.run_external ||
                    flags_nxt.data_xfer || flags_nxt.code_read;
        ale_d     = ale_allow && |(ale_hit & ale_slot_en);
        psen_d    = flags_nxt.code_fetch && !flags_nxt.data_xfer && |psen_hit;
    end

    // Output registers keep the pins glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_o         <= 1'b0;
            psen_n_o      <= 1'b1;
            ale_weak_o    <= 1'b0;
            cycle_start_o <= 1'b0;
        end else begin
            ale_o         <= ale_d;
            psen_n_o      <= !psen_d;
            ale_weak_o    <= !ale_allow;
            cycle_start_o <= (ph_nxt == '0);
        end
    end
endmodule

// File: rtl/strobe_gen_chk.sv
// Checker for the external bus strobe generator, bound to the top module.
// Tracks the machine-cycle phase from the cycle-start marker only.
module strobe_gen_chk #(
    parameter int CYC_LEN = 12,
    parameter int SLOTS   = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ale_o,
    input logic psen_n_o,
    input logic ale_weak_o,
    input logic cycle_start_o
);
    localparam int PW       = $clog2(CYC_LEN) + 1;
    localparam int SLOT_LEN = CYC_LEN / SLOTS;

    logic [PW-1:0] cnt_q;
    logic [PW-1:0] chk_ph;
    logic          seen_q;

    // Phase as implied by the cycle-start marker.
    always_comb chk_ph = cycle_start_o ? '0 : cnt_q;

    // Independent phase tracker and first-cycle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            cnt_q  <= chk_ph + 1'b1;
            if (cycle_start_o) seen_q <= 1'b1;
        end
    end

    assert_ale_slot_R2: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $rose(ale_o) |-> (int'(chk_ph) % SLOT_LEN == 0));

    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |=> !cycle_start_o);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n_o |-> !ale_o);

    assert_read_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n_o) |=> !psen_n_o);

    assert_weak_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ale_weak_o |-> !ale_o);

    assert_weak_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start_o |-> $stable(ale_weak_o));
endmodule

bind ext_bus_strobe_gen strobe_gen_chk #(.CYC_LEN(CYC_LEN), .SLOTS(SLOTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ale_o         (ale_o),
    .psen_n_o      (psen_n_o),
    .ale_weak_o    (ale_weak_o),
    .cycle_start_o (cycle_start_o)
);

// File: tb/tb_ext_bus_strobe_gen.sv
module tb_ext_bus_strobe_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_fetch_i = 1'b0, movx_i = 1'b0, movc_i = 1'b0, ext_exec_i = 1'b0, ale_off_i = 1'b0;
    logic ale_o, psen_n_o, ale_weak_o, cycle_start_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    ext_bus_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .ext_fetch_i(ext_fetch_i), .movx_i(movx_i),
        .movc_i(movc_i), .ext_exec_i(ext_exec_i), .ale_off_i(ale_off_i),
        .ale_o(ale_o), .psen_n_o(psen_n_o), .ale_weak_o(ale_weak_o),
        .cycle_start_o(cycle_start_o)
    );

    // Flag vector bits: 4 fetch, 3 movx, 2 movc, 1 ext_exec, 0 ale_off.
    function automatic bit f_allow(logic [4:0] f);
        return !f[0] || f[1] || f[3] || f[2];
    endfunction
    function automatic logic f_ale(int p, logic [4:0] f);
        return f_allow(f) && ((p == 0 || p == 1) || (!f[3] && (p == 6 || p == 7)));
    endfunction
    function automatic logic f_psen_n(int p, logic [4:0] f);
        return !(f[4] && !f[3] && ((p >= 2 && p <= 4) || (p >= 8 && p <= 10)));
    endfunction
    function automatic string ale_tag(logic [4:0] f, int p);
        if (p >= 3 && p <= 8) return "R4";
        if (f[3]) return "R5";
        if (f[0] && f[1]) return "R8";
        if (f[0] && f[2]) return "R9";
        if (f[0]) return "R7";
        return "R2";
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(logic [4:0] f);
        {ext_fetch_i, movx_i, movc_i, ext_exec_i, ale_off_i} = f;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Directed corner cases followed by random cycles.
    logic [4:0] seq [0:59];

    initial begin
        void'($urandom(32'h5EED_0042));
        seq[0]  = 5'b10000; // plain external fetch
        seq[1]  = 5'b11000; // data transfer
        seq[2]  = 5'b00001; // muted, nothing overrides
        seq[3]  = 5'b00011; // muted but external execution
        seq[4]  = 5'b00101; // muted with table read
        seq[5]  = 5'b01001; // muted with data transfer
        seq[6]  = 5'b10011; // muted, external exec, fetch
        seq[7]  = 5'b00000; // idle internal
        seq[8]  = 5'b00001; // muted twice in a row
        seq[9]  = 5'b00001;
        seq[10] = 5'b10000;
        seq[11] = 5'b11001;
        for (int i = 12; i < 60; i++) seq[i] = 5'($urandom_range(0, 31));

        // R1: reset state, with mute requested during reset.
        drive(5'b00001);
        repeat (3) @(negedge clk);
        check("R1", ale_o, 1'b0);
        check("R1", psen_n_o, 1'b1);
        check("R1", ale_weak_o, 1'b0);
        check("R1", cycle_start_o, 1'b0);

        drive(seq[0]);
        rst_n = 1'b1;
        for (int c = 0; c < 60; c++) begin
            logic [4:0] cur;
            cur = seq[c];
            for (int p = 0; p < 12; p++) begin
                @(posedge clk);
                @(negedge clk);
                check(ale_tag(cur, p), ale_o, f_ale(p, cur));
                check(cur[3] ? "R5" : "R6", psen_n_o, f_psen_n(p, cur));
                check(f_allow(cur) ? "R10" : "R7", ale_weak_o, !f_allow(cur));
                check("R3", cycle_start_o, logic'(p == 0));
                // R4: junk mid-cycle, real flags restored before phase 11.
                if (p == 3) drive(5'($urandom_range(0, 31)));
                if (p == 9) drive((c < 59) ? seq[c + 1] : 5'b00000);
            end
        end
        finish_run();
    end

    // Watchdog: a hang counts as a failed check.
    initial begin
        #(20 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule